// File: doc/BRIEF.md
# Receive Byte Buffer with Watermark Flow Control

This block sits between a serial receiver and the bus side of a UART. Each completed byte from the receiver, meaning one whose stop bit has been seen, is presented with a one-cycle valid strobe and stored in a 16-entry first-in first-out buffer. The oldest byte is always visible on the read data output. A read strobe removes it. The block reports the fill count, empty and full flags, and a sticky overrun flag. The overrun flag is set when a byte arrives while the buffer is full and is therefore lost.

The block also drives the active-low request-to-send pin. A low level tells the far end that more data may be sent. In automatic mode a hysteresis latch drives the pin from the fill count. The latch raises the pin once the count reaches a programmed high watermark and lowers it again once the count has fallen to the low watermark or below. A force control overrides the latch and drives the pin straight from a separate value bit. A flush input discards the contents, clears the overrun flag and releases the latch. The flush is pulsed when software rewrites the baud divisor.

Top module: `rx_flow_buffer`

## Requirements
- R1: After reset the buffer is empty (empty=1, full=0, fillCount=0), overrun is 0 and rtsN is 0 while forceRts is 0.
- R2: While the buffer is not empty, readData shows the oldest stored byte. A readStb in that cycle removes it, and bytes leave in the order they arrived.
- R3: A stored byte raises fillCount by one and a removed byte lowers it by one. A store and a removal in the same cycle leave it unchanged. full is 1 exactly when fillCount is 16, and empty is 1 exactly when fillCount is 0.
- R4: A byteValid that arrives while full is 1 is discarded, even if readStb is also high in that cycle. It also sets overrun, and overrun stays at 1 until flush or reset.
- R5: A readStb while empty is 1 has no effect on fillCount, on the flags or on later read data.
- R6: In automatic mode (forceRts=0), if fillCount at a clock edge is greater than or equal to highMark, then rtsN is 1 after that edge. This check takes priority over the low watermark.
- R7: In automatic mode, if fillCount at an edge is below highMark and less than or equal to lowMark, then rtsN is 0 after that edge. If it lies strictly between the two, rtsN keeps its value.
- R8: While forceRts is 1, rtsN equals rtsValue in the same cycle. The automatic latch keeps updating underneath and shows again once forceRts returns to 0.
- R9: A flush discards all stored bytes, clears overrun and the automatic latch on the next edge, and overrides any byteValid or readStb in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | One-cycle strobe, a received byte is ready |
| byteIn | input | 8 | Received byte |
| readStb | input | 1 | Remove the oldest byte |
| flush | input | 1 | Discard contents (divisor write) |
| highMark | input | 5 | Fill level that raises rtsN |
| lowMark | input | 5 | Fill level at or below which rtsN is released |
| forceRts | input | 1 | Manual override of rtsN |
| rtsValue | input | 1 | Level driven on rtsN when forced |
| readData | output | 8 | Oldest stored byte |
| fillCount | output | 5 | Number of stored bytes |
| empty | output | 1 | Buffer holds no byte |
| full | output | 1 | Buffer holds 16 bytes |
| overrun | output | 1 | Sticky flag, a byte was lost |
| rtsN | output | 1 | Active-low request-to-send |

## Verification
Pointer or count corruption appears on fillCount and the flags in the very next cycle. It appears on readData as soon as the damaged slot reaches the head, which is at most 16 reads later. A wrong hysteresis state shows on rtsN one cycle after the count crosses a watermark. The reference model compares every output on every clock, so any such divergence is reported in the cycle it first becomes visible. Stimulus fills past full, drains to empty, mixes random traffic across several watermark pairs, and toggles the override and flush.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;
endpackage

// File: rtl/rx_flow_store.sv
module rx_flow_store
  import rx_flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  count,
  output logic              isEmpty,
  output logic              isFull
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= rdPtr + 1'b1;
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dataOut = mem[rdPtr];
  assign isEmpty = (count == '0);
  assign isFull  = (count == DEPTH_C);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && !cmd.pop && !cmd.flush) |=> count == $past(count) + 1'b1);
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flush |=> isEmpty);
endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl
  import rx_flow_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             readStb,
  input  logic             flush,
  input  logic             isEmpty,
  input  logic             isFull,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] highMark,
  input  logic [CNT_W-1:0] lowMark,
  input  logic             forceRts,
  input  logic             rtsValue,
  output fifoCmd_t         cmd,
  output logic             overrun,
  output logic             rtsN
);
  logic holdOff;

  always_comb begin
    cmd.flush = flush;
    cmd.push  = byteValid && !isFull && !flush;
    cmd.pop   = readStb && !isEmpty && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
      holdOff <= 1'b0;
    end else if (flush) begin
      overrun <= 1'b0;
      holdOff <= 1'b0;
    end else begin
      if (byteValid && isFull) overrun <= 1'b1;
      if (count >= highMark)     holdOff <= 1'b1;
      else if (count <= lowMark) holdOff <= 1'b0;
    end
  end

  assign rtsN = forceRts ? rtsValue : holdOff;

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !cmd.push);
  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !flush) |=> overrun);
  assert_empty_read_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !cmd.pop);
  assert_high_mark_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !forceRts && count >= highMark) |=> (forceRts || rtsN));
  assert_low_mark_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!forceRts && count < highMark && count <= lowMark) |=> (forceRts || !rtsN));
endmodule

// File: rtl/rx_flow_buffer.sv
module rx_flow_buffer
  import rx_flow_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              readStb,
  input  logic              flush,
  input  logic [CNT_W-1:0]  highMark,
  input  logic [CNT_W-1:0]  lowMark,
  input  logic              forceRts,
  input  logic              rtsValue,
  output logic [DATA_W-1:0] readData,
  output logic [CNT_W-1:0]  fillCount,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  output logic              rtsN
);
  fifoCmd_t cmd;

  rx_flow_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .readStb(readStb),
    .flush(flush), .isEmpty(empty), .isFull(full), .count(fillCount),
    .highMark(highMark), .lowMark(lowMark), .forceRts(forceRts),
    .rtsValue(rtsValue), .cmd(cmd), .overrun(overrun), .rtsN(rtsN)
  );

  rx_flow_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataIn(byteIn), .dataOut(readData),
    .count(fillCount), .isEmpty(empty), .isFull(full)
  );
endmodule

// File: tb/test_rx_flow_buffer.sv
module test_rx_flow_buffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, readStb = 1'b0, flush = 1'b0;
  logic forceRts = 1'b0, rtsValue = 1'b0;
  logic [7:0] byteIn = '0;
  logic [4:0] highMark = 5'd12, lowMark = 5'd4;
  logic [7:0] readData;
  logic [4:0] fillCount;
  logic empty, full, overrun, rtsN;

  int vectors = 0, errors = 0;
  logic [7:0] q[$];
  bit mHold = 0, mOver = 0;

  always #2.5 clk = ~clk;

  rx_flow_buffer i_rx_flow_buffer (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .readStb(readStb), .flush(flush), .highMark(highMark), .lowMark(lowMark),
    .forceRts(forceRts), .rtsValue(rtsValue), .readData(readData),
    .fillCount(fillCount), .empty(empty), .full(full), .overrun(overrun),
    .rtsN(rtsN)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int sz = q.size();
    chk("R3 fillCount", fillCount, sz);
    chk("R3 empty", empty, sz == 0);
    chk("R3 full", full, sz == 16);
    chk("R4 overrun", overrun, mOver);
    chk(forceRts ? "R8 rtsN forced" : "R6/R7 rtsN auto", rtsN,
        forceRts ? rtsValue : mHold);
    if (sz != 0) chk("R2 readData", readData, q[0]);
  endtask

  task automatic step(bit bv, bit rd, bit fl);
    @(negedge clk);
    byteValid = bv; readStb = rd; flush = fl; byteIn = 8'($urandom);
    #1 compareAll();
    @(posedge clk);
    #1;
    if (fl) begin
      q.delete(); mOver = 0; mHold = 0;
    end else begin
      int sz = q.size();
      if (sz >= highMark) mHold = 1;
      else if (sz <= lowMark) mHold = 0;
      if (bv && sz == 16) mOver = 1;
      if (rd && sz > 0) void'(q.pop_front());
      if (bv && sz < 16) q.push_back(byteIn);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 empty", empty, 1);
    chk("R1 fillCount", fillCount, 0);
    chk("R1 rtsN", rtsN, 0);
    chk("R1 overrun", overrun, 0);
    rstN = 1'b1;
    // R5: reads on empty buffer
    repeat (3) step(0, 1, 0);
    // R6, R4: fill past full, including write+read while full
    for (int i = 0; i < 20; i++) step(1, 0, 0);
    step(1, 1, 0);
    // R2, R7: drain to empty and beyond
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    // R3: simultaneous push and pop
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    for (int i = 0; i < 10; i++) step(1, 1, 0);
    // R8: forced mode, latch keeps tracking
    forceRts = 1'b1;
    for (int i = 0; i < 12; i++) begin
      rtsValue = i[0];
      step(1, 0, 0);
    end
    forceRts = 1'b0;
    step(0, 0, 0);
    // R9: flush with simultaneous push/pop
    step(1, 1, 1);
    step(0, 0, 0);
    // random traffic over several watermark pairs
    for (int p = 0; p < 4; p++) begin
      highMark = 5'(6 + 3 * p);
      lowMark  = 5'(2 * p);
      for (int i = 0; i < 400; i++) begin
        forceRts = ($urandom % 8) == 0;
        rtsValue = 1'($urandom);
        step(($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 150) == 0);
      end
    end
    // high mark of zero wins over low mark (R6)
    forceRts = 1'b0; highMark = 5'd0; lowMark = 5'd3;
    repeat (4) step(0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule